// File: doc/BRIEF.md
# Dynamic Output-Voltage Reference Ramp

The block converts an 8-bit setpoint code and a 2-bit range selector into a target output voltage. The target is expressed as an integer number of microvolts. It then moves an internal reference toward that target, once per 1 µs timing tick, so that the regulator it feeds never sees a step in its reference. The reference can move in two ways. After enable it climbs from zero along a soft-start ramp, whose duration is chosen by a 2-bit code. Once it has settled, a later change of code or range makes it glide at one of four encoded slew rates, and it stops exactly on the new target.

The block raises a busy flag while a ramp is in progress. It also drives a power-good masking control. When blanking is enabled, the mask is held high for the length of a setpoint glide, so that the window comparator's verdict is hidden while the output is legitimately moving. The DAC that turns the reference into a voltage is outside the block, and so is the comparator.

Top module: `dvs_ref_ramp`

## Requirements
- R1: The target in µV is the base plus the code times the step. For range 00, 01 and 10 the base is 400000, and for range 11 it is 800000. The step is 1250, 2500, 5000 and 10000 µV for range 00, 01, 10 and 11. A finished ramp leaves the reference equal to this target.
- R2: After reset, ref_uv is 0, busy is 0 and pg_mask is 0.
- R3: On the first clock with enable high after it was low, a soft-start begins and busy rises. Each tick adds ceil(target/T) µV. T is 500, 1000, 2000 or 4000 for soft_sel 00, 01, 10 or 11. The target is therefore reached within T ticks.
- R4: A glide moves the reference by the slew amount on each tick. The slew is 10000, 5000, 1250 or 500 µV for slew_sel 00, 01, 10 or 11. The number of ticks is ceil(|difference| / slew).
- R5: The reference changes only on a clock with tick_1us high. It never passes the target: the last step is clamped.
- R6: If the code changes during a glide, the glide heads for the new target from the present reference value, with no jump.
- R7: With enable low, ref_uv becomes 0 and busy and pg_mask become 0 at the next clock.
- R8: pg_mask is high only while a setpoint glide is active and blank_en is high. It stays low during soft-start and whenever blank_en is low.
- R9: From the settled state, a change of target raises busy at the next clock. busy falls at the tick on which the reference reaches the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-clock strobe every microsecond |
| enable | input | 1 | Regulator enable |
| vcode | input | 8 | Setpoint code |
| vrange | input | 2 | Range selector |
| slew_sel | input | 2 | Glide slew-rate code |
| soft_sel | input | 2 | Soft-start duration code |
| blank_en | input | 1 | Power-good blanking enable during glides |
| ref_uv | output | 22 | Reference voltage in µV |
| busy | output | 1 | Ramp in progress |
| pg_mask | output | 1 | Power-good indication masked |

## Verification
Some properties hold on every cycle, and the assertions check those. The reference stays still between ticks. It never moves further on a tick than the step selected for the current phase, and it never crosses the target. Disable forces it to zero at the next clock. The mask is never high outside a glide, and never high during soft-start. The bench scenarios show the arithmetic that only end states reveal. They check the target value of every range across a stride of codes, the four slew rates in both directions, and the tick counts of the four soft-start durations. They also show that a glide retargeted part-way continues from where it stood.

// File: rtl/dvs_ramp_pkg.sv
package dvs_ramp_pkg;
  typedef logic [31:0] wide_t;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_SOFT  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_GLIDE = 2'd3
  } ramp_st_e;

  function automatic wide_t range_base_uv(input logic [1:0] rng);
    return (rng == 2'b11) ? wide_t'(800000) : wide_t'(400000);
  endfunction

  function automatic wide_t range_lsb_uv(input logic [1:0] rng);
    case (rng)
      2'b00:   return wide_t'(1250);
      2'b01:   return wide_t'(2500);
      2'b10:   return wide_t'(5000);
      default: return wide_t'(10000);
    endcase
  endfunction

  function automatic wide_t slew_uv(input logic [1:0] sel);
    case (sel)
      2'b00:   return wide_t'(10000);
      2'b01:   return wide_t'(5000);
      2'b10:   return wide_t'(1250);
      default: return wide_t'(500);
    endcase
  endfunction

  function automatic wide_t soft_ticks(input logic [1:0] sel);
    return wide_t'(500) << sel;
  endfunction

  function automatic wide_t ceil_div(input wide_t num, input wide_t den);
    return (num + den - 1) / den;
  endfunction

  function automatic wide_t approach(input wide_t cur, input wide_t tgt, input wide_t step);
    if (cur < tgt)      return ((tgt - cur) <= step) ? tgt : cur + step;
    else if (cur > tgt) return ((cur - tgt) <= step) ? tgt : cur - step;
    else                return cur;
  endfunction
endpackage

// File: rtl/dvs_target_map.sv
module dvs_target_map
  import dvs_ramp_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int UV_W   = 22
) (
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        rng,
  output logic [UV_W-1:0]   target_uv
);
  localparam int N_RANGES = 4;

  logic [UV_W-1:0] cand [N_RANGES];

  for (genvar g = 0; g < N_RANGES; g++) begin : g_rng
    assign cand[g] = UV_W'(range_base_uv(2'(g)) + range_lsb_uv(2'(g)) * wide_t'(code));
  end

  assign target_uv = cand[rng];
endmodule

// File: rtl/dvs_step_sel.sv
module dvs_step_sel
  import dvs_ramp_pkg::*;
#(
  parameter int UV_W = 22
) (
  input  logic [1:0]      slew_sel,
  input  logic [1:0]      soft_sel,
  input  logic [UV_W-1:0] target_uv,
  output logic [UV_W-1:0] glide_step,
  output logic [UV_W-1:0] soft_step
);
  assign glide_step = UV_W'(slew_uv(slew_sel));
  assign soft_step  = UV_W'(ceil_div(wide_t'(target_uv), soft_ticks(soft_sel)));
endmodule

// File: rtl/dvs_ramp_core.sv
module dvs_ramp_core
  import dvs_ramp_pkg::*;
#(
  parameter int UV_W = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            enable,
  input  logic [UV_W-1:0] target_uv,
  input  logic [UV_W-1:0] glide_step,
  input  logic [UV_W-1:0] soft_step,
  output logic [UV_W-1:0] ref_uv,
  output logic [UV_W-1:0] step_cur,
  output logic            soft_active,
  output logic            glide_active
);
  ramp_st_e        st_q, st_d;
  logic [UV_W-1:0] ref_q, ref_d;
  logic [UV_W-1:0] soft_q, soft_d;
  logic [UV_W-1:0] moved;

  always_comb begin
    step_cur = (st_q == ST_SOFT) ? soft_q : glide_step;
    moved    = UV_W'(approach(wide_t'(ref_q), wide_t'(target_uv), wide_t'(step_cur)));
    st_d     = st_q;
    ref_d    = ref_q;
    soft_d   = soft_q;
    if (!enable) begin
      st_d  = ST_OFF;
      ref_d = '0;
    end else begin
      case (st_q)
        ST_OFF: begin
          st_d   = ST_SOFT;
          soft_d = soft_step;
        end
        ST_SOFT, ST_GLIDE: begin
          if (tick) begin
            ref_d = moved;
            if (moved == target_uv) st_d = ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (ref_q != target_uv) st_d = ST_GLIDE;
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      ref_q  <= '0;
      soft_q <= '0;
    end else begin
      st_q   <= st_d;
      ref_q  <= ref_d;
      soft_q <= soft_d;
    end
  end

  assign ref_uv       = ref_q;
  assign soft_active  = (st_q == ST_SOFT);
  assign glide_active = (st_q == ST_GLIDE);
endmodule

// File: rtl/dvs_ref_ramp.sv
module dvs_ref_ramp #(
  parameter int CODE_W = 8,
  parameter int UV_W   = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1us,
  input  logic              enable,
  input  logic [CODE_W-1:0] vcode,
  input  logic [1:0]        vrange,
  input  logic [1:0]        slew_sel,
  input  logic [1:0]        soft_sel,
  input  logic              blank_en,
  output logic [UV_W-1:0]   ref_uv,
  output logic              busy,
  output logic              pg_mask
);
  logic [UV_W-1:0] target_uv;
  logic [UV_W-1:0] glide_step;
  logic [UV_W-1:0] soft_step;
  logic [UV_W-1:0] step_cur;
  logic            soft_active;
  logic            glide_active;

  dvs_target_map #(.CODE_W(CODE_W), .UV_W(UV_W)) u_map (
    .code      (vcode),
    .rng       (vrange),
    .target_uv (target_uv)
  );

  dvs_step_sel #(.UV_W(UV_W)) u_steps (
    .slew_sel   (slew_sel),
    .soft_sel   (soft_sel),
    .target_uv  (target_uv),
    .glide_step (glide_step),
    .soft_step  (soft_step)
  );

  dvs_ramp_core #(.UV_W(UV_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick_1us),
    .enable       (enable),
    .target_uv    (target_uv),
    .glide_step   (glide_step),
    .soft_step    (soft_step),
    .ref_uv       (ref_uv),
    .step_cur     (step_cur),
    .soft_active  (soft_active),
    .glide_active (glide_active)
  );

  assign busy    = soft_active | glide_active;
  assign pg_mask = blank_en & glide_active;
endmodule

// File: rtl/dvs_ref_ramp_chk.sv
module dvs_ref_ramp_chk #(
  parameter int UV_W = 22
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            tick,
  input logic            blank_en,
  input logic [UV_W-1:0] ref_uv,
  input logic [UV_W-1:0] target_uv,
  input logic [UV_W-1:0] step_cur,
  input logic            soft_active,
  input logic            busy,
  input logic            pg_mask
);
  function automatic logic [UV_W-1:0] absdiff(input logic [UV_W-1:0] a, input logic [UV_W-1:0] b);
    return (a >= b) ? a - b : b - a;
  endfunction

  // R5
  ref_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> (ref_uv == $past(ref_uv)));

  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick) |=> (absdiff(ref_uv, $past(ref_uv)) <= $past(step_cur)));

  // R5
  no_overshoot_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && ref_uv <= target_uv) |=> (ref_uv <= $past(target_uv)));

  // R5
  no_overshoot_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && ref_uv >= target_uv) |=> (ref_uv >= $past(target_uv)));

  // R7
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (ref_uv == '0 && !busy && !pg_mask));

  // R8
  mask_needs_glide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_mask |-> (busy && blank_en));

  // R8
  mask_soft_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_active |-> !pg_mask);
endmodule

bind dvs_ref_ramp dvs_ref_ramp_chk #(.UV_W(UV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .tick        (tick_1us),
  .blank_en    (blank_en),
  .ref_uv      (ref_uv),
  .target_uv   (target_uv),
  .step_cur    (step_cur),
  .soft_active (soft_active),
  .busy        (busy),
  .pg_mask     (pg_mask)
);

// File: tb/dvs_ref_ramp_bench.sv
module dvs_ref_ramp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  vcode = '0;
  logic [1:0]  vrange = '0;
  logic [1:0]  slew_sel = '0;
  logic [1:0]  soft_sel = '0;
  logic        blank_en = 1'b0;
  logic [21:0] ref_uv;
  logic        busy;
  logic        pg_mask;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int prev_exp = 0;

  always #2 clk = ~clk;

  dvs_ref_ramp u_dvs_ref_ramp (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick), .enable(enable),
    .vcode(vcode), .vrange(vrange), .slew_sel(slew_sel), .soft_sel(soft_sel),
    .blank_en(blank_en), .ref_uv(ref_uv), .busy(busy), .pg_mask(pg_mask)
  );

  function automatic int exp_target(input int r, input int c);
    int base = (r == 3) ? 800000 : 400000;
    int lsb  = (r == 3) ? 10000 : (1250 << r);
    return base + c * lsb;
  endfunction

  function automatic int exp_slew(input int s);
    int tbl[4] = '{10000, 5000, 1250, 500};
    return tbl[s];
  endfunction

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic run_idle(input int max_ticks, output int n);
    n = 0;
    while (busy && n < max_ticks) begin
      pulse();
      n++;
    end
  endtask

  task automatic glide_to(input int r, input int c, input string tag);
    int e = exp_target(r, c);
    int d = (e > prev_exp) ? e - prev_exp : prev_exp - e;
    int s = exp_slew(int'(slew_sel));
    int first;
    int n;
    @(negedge clk);
    vrange = 2'(r);
    vcode  = 8'(c);
    @(negedge clk);
    if (d == 0) begin
      check(busy == 1'b0, {tag, " R9 idle"}, int'(busy), 0);
    end else begin
      check(busy == 1'b1, {tag, " R9 busy"}, int'(busy), 1);
      check(pg_mask == blank_en, {tag, " R8 mask"}, int'(pg_mask), int'(blank_en));
      first = (d <= s) ? e : ((e > prev_exp) ? prev_exp + s : prev_exp - s);
      pulse();
      check(int'(ref_uv) == first, {tag, " R4 first"}, int'(ref_uv), first);
      run_idle(5000, n);
      check(n + 1 == cdiv(d, s), {tag, " R4 ticks"}, n + 1, cdiv(d, s));
    end
    check(int'(ref_uv) == e, {tag, " R1 final"}, int'(ref_uv), e);
    check(busy == 1'b0, {tag, " R9 done"}, int'(busy), 0);
    prev_exp = e;
  endtask

  task automatic soft_run(input int r, input int c, input int s, input string tag);
    int e = exp_target(r, c);
    int tt = 500 << s;
    int st = cdiv(e, tt);
    int n;
    int hold;
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(ref_uv == '0 && !busy && !pg_mask, {tag, " R7 off"}, int'(ref_uv), 0);
    vrange = 2'(r);
    vcode = 8'(c);
    soft_sel = 2'(s);
    enable = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, {tag, " R3 busy"}, int'(busy), 1);
    check(pg_mask == 1'b0, {tag, " R8 soft mask"}, int'(pg_mask), 0);
    pulse();
    check(int'(ref_uv) == st, {tag, " R3 step"}, int'(ref_uv), st);
    hold = int'(ref_uv);
    @(negedge clk);
    @(negedge clk);
    check(int'(ref_uv) == hold, {tag, " R5 still"}, int'(ref_uv), hold);
    run_idle(5000, n);
    check(n + 1 == cdiv(e, st), {tag, " R3 ticks"}, n + 1, cdiv(e, st));
    check(n + 1 <= tt, {tag, " R3 within"}, n + 1, tt);
    check(int'(ref_uv) == e, {tag, " R3 final"}, int'(ref_uv), e);
    prev_exp = e;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(ref_uv == '0 && !busy && !pg_mask, "R2 reset", int'(ref_uv), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ref_uv == '0 && !busy, "R2 after release", int'(ref_uv), 0);

    blank_en = 1'b1;
    soft_run(3, 255, 0, "ss max");
    for (int s = 0; s < 4; s++) soft_run(0, 1, s, "ss sweep");
    soft_run(2, 77, 3, "ss mid");

    slew_sel = 2'd0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c <= 255; c += 15) glide_to(r, c, "range sweep");

    glide_to(3, 0, "slew base");
    for (int s = 0; s < 4; s++) begin
      slew_sel = 2'(s);
      glide_to(3, 100, "slew up");
      glide_to(3, 0, "slew down");
    end

    // R6: retarget mid-glide
    slew_sel = 2'd2;
    @(negedge clk);
    vcode = 8'd200;
    @(negedge clk);
    for (int i = 0; i < 10; i++) pulse();
    check(int'(ref_uv) == 812500, "R6 partway", int'(ref_uv), 812500);
    vcode = 8'd1;
    @(negedge clk);
    check(int'(ref_uv) == 812500 && busy, "R6 no jump", int'(ref_uv), 812500);
    pulse();
    check(int'(ref_uv) == 811250, "R6 reverse", int'(ref_uv), 811250);
    pulse();
    check(int'(ref_uv) == 810000 && !busy, "R6 land", int'(ref_uv), 810000);
    prev_exp = 810000;

    // R8: blanking off
    blank_en = 1'b0;
    slew_sel = 2'd0;
    @(negedge clk);
    vcode = 8'd40;
    @(negedge clk);
    check(busy && !pg_mask, "R8 unblanked", int'(pg_mask), 0);
    run_idle(5000, n);
    check(int'(ref_uv) == 1200000, "R1 unblanked final", int'(ref_uv), 1200000);

    // R7: disable mid-glide
    blank_en = 1'b1;
    @(negedge clk);
    vcode = 8'd90;
    @(negedge clk);
    pulse();
    pulse();
    check(int'(ref_uv) == 1220000 && pg_mask, "R7 pre", int'(ref_uv), 1220000);
    enable = 1'b0;
    @(negedge clk);
    check(ref_uv == '0 && !busy && !pg_mask, "R7 disable", int'(ref_uv), 0);

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule